// File: doc/BRIEF.md
# Configurable External Bus Cycle Sequencer

This block turns one internal access request into the strobe sequence of a single external memory cycle. A set of configuration inputs, already chosen for the target window, shapes that sequence. It fixes the address-latch pulse length and an optional one-clock gap before the read or write strobe. It also fixes the minimum strobe length, a stretch that waits for an external ready pin of either polarity, a turnaround clock after the access, and one of four bus shapes: 8 or 16 bits wide, with the address either multiplexed onto the data lines or kept on separate lines. One clock of the sequencer is the basic time unit.

A requester raises `reqValid` for one clock while the block is idle. Address, write data and direction are captured on that edge. The requester then waits for the single-clock `done` pulse. On a read, `rdData` holds the captured bus value from that pulse onward. The configuration inputs must stay stable from the request until `done`. When the bus-enable input is low, the request is acknowledged at once and nothing happens on the external pins.

Top module: `extBusSeq`

## Requirements
- R1: With ready disabled, the read/write strobe stays high for exactly 16 - cfgWait clocks, so code 0 gives 15 wait clocks after the first strobe clock and code 15 gives none.
- R2: With cfgRwFast = 0 there is exactly one clock with neither the latch pulse nor a strobe between the fall of `ale` and the rise of the strobe. With cfgRwFast = 1 the strobe rises in the clock right after `ale` falls.
- R3: With cfgTriFast = 0, one idle turnaround clock follows the last strobe clock before `done`. With cfgTriFast = 1 there is none. For an enabled bus, `done` comes (1+cfgLongAle) + (1-cfgRwFast) + strobe length + (1-cfgTriFast) + 1 clocks after the accepting edge.
- R4: `ale` is high for one clock when cfgLongAle = 0 and for two clocks when cfgLongAle = 1. It is never high together with a strobe.
- R5: cfgBusMode bit 1 selects width (0 = 8 bits, 1 = 16 bits) and bit 0 selects multiplexing (1 = multiplexed). In multiplexed modes the bus drives the address while `ale` is high. In separate-address modes the bus is not driven then. In 8-bit modes bus bits 15:8 stay 0 and read data bits 15:8 read 0. `addrOut` holds the request address throughout.
- R6: A write drives the write data on the bus from the clock after `ale` falls through the last strobe clock, using `wrStrobe`. A read asserts `rdStrobe`, leaves the bus undriven after `ale`, and returns the bus value of the last strobe clock on `rdData` at `done`.
- R7: With cfgBusOn = 0, `done` follows one clock after the accepting edge, `rdData` is 0, and `ale`, both strobes and `busOe` stay low.
- R8: With cfgRdyEn = 1 the strobe lasts at least 16 - cfgWait clocks and then holds until the ready pin, passed through a two-flop synchronizer, is at its active level. A pin that turns active while strobe clock K (counted from 0) is high ends the strobe after max(K+3, 16-cfgWait) clocks. With cfgRdyEn = 0 the ready pin has no effect.
- R9: cfgRdyHigh = 1 makes a high ready pin active. cfgRdyHigh = 0 makes a low pin active.
- R10: `done` is a single-clock pulse. `reqValid` is taken only while idle, so a request raised during a cycle starts nothing. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one time unit per period |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-clock request, accepted only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 16 | Write data |
| cfgWait | input | 4 | Wait code, wait clocks = 15 - code |
| cfgRwFast | input | 1 | 1 = no gap clock before the strobe |
| cfgTriFast | input | 1 | 1 = no turnaround clock after the access |
| cfgBusMode | input | 2 | Bit 1 width (16 bits), bit 0 multiplexed |
| cfgLongAle | input | 1 | 1 = two-clock address latch pulse |
| cfgBusOn | input | 1 | 0 = acknowledge without an external cycle |
| cfgRdyEn | input | 1 | 1 = strobe end waits for ready pin |
| cfgRdyHigh | input | 1 | Ready active level |
| readyPin | input | 1 | Asynchronous external ready |
| busIn | input | 16 | Data bus input value |
| ale | output | 1 | Address latch enable |
| rdStrobe | output | 1 | Read strobe, active high |
| wrStrobe | output | 1 | Write strobe, active high |
| addrOut | output | 16 | Separate address lines |
| busOut | output | 16 | Data bus output value, 0 when not driven |
| busOe | output | 1 | Data bus output enable |
| rdData | output | 16 | Read result, valid from `done` |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench sweeps every wait code against both latch lengths, both gap and turnaround settings, all four bus shapes and both directions. For each sweep point it compares the measured strobe length, gap, latch length and completion time with sums worked out from the settings. An off-by-one in the 15-minus-code decode, or a gap or turnaround clock applied the wrong way round, would shift the completion time or the strobe length. Ready is released at several strobe clocks with both polarities, against a minimum longer and shorter than the synchronizer delay. A design that skipped the minimum, sampled the pin without synchronizing it or inverted the polarity would end the strobe early or late. Bus-off requests, stray requests raised mid-cycle and narrow-mode masking are also probed. A design that got these wrong would strobe the pins, start a second cycle, or leak upper bytes onto the bus or into the read data.

// File: rtl/ebsPkg.sv
package ebsPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ALE, ST_GAP, ST_ACC, ST_TURN, ST_FIN
  } ebsState_t;

  // Strobes from control to datapath and pins
  typedef struct packed {
    logic ale;
    logic dataPhase;
    logic rd;
    logic wr;
    logic capture;
    logic load;
    logic clearRd;
    logic done;
  } ebsStrobe_t;
endpackage

// File: rtl/ebsCtrl.sv
module ebsCtrl
  import ebsPkg::*;
#(
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgRwFast,
  input  logic              cfgTriFast,
  input  logic              cfgLongAle,
  input  logic              cfgBusOn,
  input  logic              cfgRdyEn,
  input  logic              cfgRdyHigh,
  input  logic              readyPin,
  input  logic              curWrite,
  output ebsStrobe_t        stb
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  ebsState_t         state;
  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] waitLimit;
  logic [WAIT_W-1:0] aleLimit;
  logic              rdySynced;
  logic              rdyOk;
  logic              accDone;

  // Ready synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= readyPin;
      assign rdySynced = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], readyPin};
      assign rdySynced = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  assign waitLimit = WAIT_MAX - cfgWait;
  assign aleLimit  = {{(WAIT_W-1){1'b0}}, cfgLongAle};
  assign rdyOk     = (rdySynced == cfgRdyHigh);
  assign accDone   = (cnt == waitLimit) && (!cfgRdyEn || rdyOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= cfgBusOn ? ST_ALE : ST_FIN;
          cnt   <= '0;
        end
        ST_ALE: if (cnt == aleLimit) begin
          state <= cfgRwFast ? ST_ACC : ST_GAP;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_GAP: begin
          state <= ST_ACC;
          cnt   <= '0;
        end
        ST_ACC: if (accDone) begin
          state <= cfgTriFast ? ST_FIN : ST_TURN;
        end else if (cnt != waitLimit) begin
          cnt <= cnt + 1'b1;
        end
        ST_TURN: state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.ale       = (state == ST_ALE);
    stb.dataPhase = (state == ST_GAP) || (state == ST_ACC);
    stb.rd        = (state == ST_ACC) && !curWrite;
    stb.wr        = (state == ST_ACC) && curWrite;
    stb.capture   = (state == ST_ACC) && accDone && !curWrite;
    stb.load      = (state == ST_IDLE) && reqValid;
    stb.clearRd   = stb.load && !cfgBusOn;
    stb.done      = (state == ST_FIN);
  end
endmodule

// File: rtl/ebsDatapath.sv
module ebsDatapath
  import ebsPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ebsStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        cfgBusMode,
  input  logic [DATA_W-1:0] busIn,
  output logic              curWrite,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rdData
);
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] laneMask;
  logic              muxed;

  assign muxed    = cfgBusMode[0];
  assign laneMask = cfgBusMode[1] ? {DATA_W{1'b1}}
                                  : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      curWrite <= 1'b0;
    end else if (stb.load) begin
      addrQ    <= reqAddr;
      wdataQ   <= reqWdata;
      curWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (stb.clearRd) rdData <= '0;
    else if (stb.capture) rdData <= busIn & laneMask;
  end

  assign busOe   = (stb.ale && muxed) || (stb.dataPhase && curWrite);
  assign addrOut = addrQ;

  always_comb begin
    if (!busOe)       busOut = '0;
    else if (stb.ale) busOut = DATA_W'(addrQ) & laneMask;
    else              busOut = wdataQ & laneMask;
  end
endmodule

// File: rtl/extBusSeq.sv
module extBusSeq
  import ebsPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgRwFast,
  input  logic              cfgTriFast,
  input  logic [1:0]        cfgBusMode,
  input  logic              cfgLongAle,
  input  logic              cfgBusOn,
  input  logic              cfgRdyEn,
  input  logic              cfgRdyHigh,
  input  logic              readyPin,
  input  logic [DATA_W-1:0] busIn,
  output logic              ale,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  ebsStrobe_t stb;
  logic       curWrite;

  ebsCtrl #(.WAIT_W(WAIT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgWait(cfgWait),
    .cfgRwFast(cfgRwFast), .cfgTriFast(cfgTriFast), .cfgLongAle(cfgLongAle),
    .cfgBusOn(cfgBusOn), .cfgRdyEn(cfgRdyEn), .cfgRdyHigh(cfgRdyHigh),
    .readyPin(readyPin), .curWrite(curWrite), .stb(stb)
  );

  ebsDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .cfgBusMode(cfgBusMode),
    .busIn(busIn), .curWrite(curWrite), .addrOut(addrOut),
    .busOut(busOut), .busOe(busOe), .rdData(rdData)
  );

  assign ale      = stb.ale;
  assign rdStrobe = stb.rd;
  assign wrStrobe = stb.wr;
  assign done     = stb.done;
endmodule

// File: rtl/ebsChecker.sv
module ebsChecker (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic rdStrobe,
  input logic wrStrobe,
  input logic busOe,
  input logic done,
  input logic cfgRwFast
);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_ale_apart_r4: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> !(rdStrobe || wrStrobe));

  p_ale_max_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ale && $past(ale)) |=> !ale);

  p_rw_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ale) && !cfgRwFast) |-> !(rdStrobe || wrStrobe));

  p_read_float_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> !busOe);

  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> busOe);
endmodule

bind extBusSeq ebsChecker u_chk (
  .clk(clk), .rstN(rstN), .ale(ale), .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe), .busOe(busOe), .done(done), .cfgRwFast(cfgRwFast)
);

// File: tb/sim_extBusSeq.sv
module sim_extBusSeq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, reqValid, reqWrite;
  logic [15:0] reqAddr, reqWdata, busIn;
  logic [3:0] cfgWait;
  logic cfgRwFast, cfgTriFast, cfgLongAle, cfgBusOn, cfgRdyEn, cfgRdyHigh, readyPin;
  logic [1:0] cfgBusMode;
  logic ale, rdStrobe, wrStrobe, busOe, done;
  logic [15:0] addrOut, busOut, rdData;

  int errors = 0;
  int checks = 0;

  extBusSeq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .cfgWait(cfgWait),
    .cfgRwFast(cfgRwFast), .cfgTriFast(cfgTriFast), .cfgBusMode(cfgBusMode),
    .cfgLongAle(cfgLongAle), .cfgBusOn(cfgBusOn), .cfgRdyEn(cfgRdyEn),
    .cfgRdyHigh(cfgRdyHigh), .readyPin(readyPin), .busIn(busIn),
    .ale(ale), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .addrOut(addrOut),
    .busOut(busOut), .busOe(busOe), .rdData(rdData), .done(done)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One transaction; rdyK < 0 keeps ready at a fixed level
  task automatic runTxn(input bit wr, input logic [15:0] addr, input logic [15:0] wdata,
                        input logic [15:0] inVal, input int rdyK);
    int a, d, s, t, waits, expDone;
    int k, doneK, aleCnt, stbCnt, firstStb, lastAle, busErr, kindErr, idleErr;
    logic [15:0] mask, expOut;
    bit mux, expOe;
    a = 1 + cfgLongAle;
    d = cfgRwFast ? 0 : 1;
    t = cfgTriFast ? 0 : 1;
    waits = 15 - cfgWait;
    s = waits + 1;
    if (cfgRdyEn && rdyK >= 0 && rdyK + 3 > s) s = rdyK + 3;
    expDone = cfgBusOn ? (a + d + s + t + 1) : 1;
    mux  = cfgBusMode[0];
    mask = cfgBusMode[1] ? 16'hFFFF : 16'h00FF;
    readyPin = (cfgRdyEn && rdyK < 0) ? cfgRdyHigh : !cfgRdyHigh;
    busIn = inVal;
    idleErr = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (ale || rdStrobe || wrStrobe || done) idleErr++;
    end
    reqWrite = wr; reqAddr = addr; reqWdata = wdata; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    doneK = 0; aleCnt = 0; stbCnt = 0; firstStb = 0; lastAle = 0; busErr = 0; kindErr = 0;
    for (k = 1; k <= 60; k++) begin
      if (ale) begin
        aleCnt++; lastAle = k;
        expOe = mux; expOut = mux ? (addr & mask) : 16'h0;
      end else if (rdStrobe || wrStrobe) begin
        stbCnt++;
        if (firstStb == 0) firstStb = k;
        if (wrStrobe != wr || rdStrobe == wr) kindErr++;
        expOe = wr; expOut = wr ? (wdata & mask) : 16'h0;
        if (cfgRdyEn && rdyK >= 0 && stbCnt - 1 == rdyK) readyPin = cfgRdyHigh;
      end else begin
        expOe = cfgBusOn && wr && d == 1 && k == a + 1;
        expOut = expOe ? (wdata & mask) : 16'h0;
      end
      if (busOe != expOe || busOut != expOut || addrOut != addr) busErr++;
      if (k == 2) reqValid = 1'b1;   // stray request mid-cycle
      if (k == 3) reqValid = 1'b0;
      if (done) begin doneK = k; break; end
      @(negedge clk);
    end
    reqValid = 1'b0;
    check("R10 idle before request", idleErr, 0);
    if (cfgBusOn) begin
      check(cfgTriFast ? "R3 done latency fast" : "R3 done latency turnaround", doneK, expDone);
      check("R4 ale length", aleCnt, a);
      check(cfgRdyEn ? (cfgRdyHigh ? "R8 R9 strobe length high" : "R8 R9 strobe length low")
                     : "R1 strobe length", stbCnt, s);
      check("R2 ale to strobe gap", firstStb - lastAle - 1, d);
      check("R5 bus drive", busErr, 0);
      check("R6 strobe kind", kindErr, 0);
    end else begin
      check("R7 bus off latency", doneK, 1);
      check("R7 bus off no activity", aleCnt + stbCnt + busErr, 0);
    end
    if (!wr) check("R6 R5 read data", rdData, cfgBusOn ? (inVal & mask) : 16'h0);
    @(negedge clk);
    check("R10 done pulse and stray ignored", {done, ale, rdStrobe, wrStrobe}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    busIn = '0; cfgWait = '0; cfgRwFast = 1'b0; cfgTriFast = 1'b0; cfgBusMode = 2'b00;
    cfgLongAle = 1'b0; cfgBusOn = 1'b1; cfgRdyEn = 1'b0; cfgRdyHigh = 1'b0; readyPin = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset state", {ale, rdStrobe, wrStrobe, busOe, done}, 0);
    check("R6 reset read data", rdData, 0);
    rstN = 1'b1;
    n = 0;
    // Full timing and bus shape sweep, ready disabled and held inactive (R8)
    for (int m = 0; m < 4; m++)
      for (int la = 0; la < 2; la++)
        for (int rf = 0; rf < 2; rf++)
          for (int tf = 0; tf < 2; tf++)
            for (int w = 0; w < 16; w++)
              for (int wr = 0; wr < 2; wr++) begin
                cfgBusMode = 2'(m); cfgLongAle = la[0]; cfgRwFast = rf[0];
                cfgTriFast = tf[0]; cfgWait = 4'(w); cfgRdyHigh = w[0];
                n++;
                runTxn(wr[0], 16'hA5C3 ^ 16'(n * 16'h1357), 16'h3C96 + 16'(n * 16'h0B1D),
                       16'hE71B ^ 16'(n * 16'h2469), -1);
              end
    // Ready handshake, both polarities
    cfgRdyEn = 1'b1;
    for (int pol = 0; pol < 2; pol++)
      for (int wi = 0; wi < 3; wi++)
        for (int kk = -1; kk < 7; kk++)
          for (int m = 0; m < 4; m += 3)
            for (int wr = 0; wr < 2; wr++) begin
              cfgRdyHigh = pol[0];
              cfgWait = (wi == 0) ? 4'd15 : (wi == 1) ? 4'd13 : 4'd10;
              cfgBusMode = 2'(m); cfgLongAle = kk[0]; cfgRwFast = wr[0]; cfgTriFast = pol[0];
              n++;
              runTxn(wr[0], 16'h1234 + 16'(n), 16'hBEEF ^ 16'(n), 16'h8421 + 16'(n * 7), kk);
            end
    // Bus disabled
    cfgBusOn = 1'b0;
    for (int m = 0; m < 4; m++)
      for (int wr = 0; wr < 2; wr++) begin
        cfgBusMode = 2'(m); cfgRdyEn = m[0]; cfgWait = 4'(m * 3);
        runTxn(wr[0], 16'hFACE, 16'h5A5A, 16'hFFFF, 2);
      end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule